// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block sits behind the register port of a multi-queue host controller and handles every write that lands in the doorbell window at or above offset 0x1000. Each queue pair owns two 4-byte slots, interleaved: the first holds the submission-queue tail and the second holds the completion-queue head. The decoder works out which kind of doorbell was hit and which queue it names. It checks that the queue exists and that the new pointer lies inside the queue, and it stores the pointer in a per-queue register.

Each accepted write produces one-cycle event pulses that carry a queue number. A tail write asks the command fetcher to look at that submission queue. A head write re-raises the queue's interrupt while unread completions remain. If the completion queue was full just before the host freed space, the decoder also issues a restart pulse. That pulse wakes the completion poster for the queue and, through a bit mask, every submission queue bound to it. Queue existence, sizes, the poster's current completion tail and the binding masks come in as configuration inputs from the controller's queue manager.

Top module: `qdb_decoder`

## Requirements
- R1: After a synchronous active-low reset, every stored tail and head is 0 and no event output is high.
- R2: A write whose address has either of bits 1:0 set, or whose address is below 0x1000, changes no pointer and raises no event.
- R3: For an offset o of 0x1000 or more, bit 2 of (o - 0x1000) picks the doorbell kind (0 for a submission tail, 1 for a completion head), and bits above bit 2 of (o - 0x1000), that is (o - 0x1000) >> 3, give the queue number.
- R4: The pointer value is taken from bits 15:0 of the write data; the upper data bits have no effect.
- R5: A write to a queue whose enable bit is clear, or whose queue number is NQ or more, changes no pointer and raises no event.
- R6: A write whose value is equal to or greater than the queue's size (size is the entry count) is dropped with no pointer change and no event.
- R7: An accepted tail write stores the tail, and on the next clock fetch_vld is high for one cycle with fetch_qid equal to the queue number.
- R8: When an accepted head write finds its completion queue full beforehand (the poster tail plus one, wrapping at the size, equals the old head), restart_vld pulses one cycle after the write with restart_cqid set to that queue number and restart_sqs set to the bit mask of the submission queues bound to it.
- R9: An accepted head write raises irq_vld for one cycle on the next clock with irq_qid set to the queue number whenever the new head differs from the poster tail.
- R10: Every event is a single-cycle pulse that follows only the write it answers, so back-to-back accepted writes give pulses on back-to-back cycles and idle cycles give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| sq_valid | input | NQ | Submission queue exists, one bit per queue |
| sq_size | input | NQ*16 | Entry count of each submission queue |
| cq_valid | input | NQ | Completion queue exists, one bit per queue |
| cq_size | input | NQ*16 | Entry count of each completion queue |
| cq_tail | input | NQ*16 | Current completion tail held by the poster |
| cq_bind | input | NQ*NQ | Per completion queue, mask of bound submission queues |
| sq_tail | output | NQ*16 | Stored submission tails |
| cq_head | output | NQ*16 | Stored completion heads |
| fetch_vld | output | 1 | Fetch request pulse |
| fetch_qid | output | QID_W | Submission queue to fetch from |
| restart_vld | output | 1 | Full-queue restart pulse |
| restart_cqid | output | QID_W | Completion queue whose poster restarts |
| restart_sqs | output | NQ | Submission queues to reschedule |
| irq_vld | output | 1 | Interrupt re-signal pulse |
| irq_qid | output | QID_W | Completion queue to re-signal |

## Verification
The hardest case to reach is a completion queue that is full at the moment its head is written, because fullness depends on the poster tail, the queue size and the previously stored head all together. The stimulus sets the poster tail one slot behind a head it has just written, and then moves the head to trigger the restart. It also covers the wrap case, where the tail is the last slot and a head still at zero already means full. A behavioural model in the bench tracks every pointer and predicts each pulse on every clock, so that dropped writes are shown to leave all state untouched.

// File: rtl/qdb_pkg.sv
// Shared constants and helpers for the doorbell decoder.
// Assumes pointers are 16 bits wide, as carried in the low half of a write.
package qdb_pkg;
    localparam int PTR_W = 16;

    typedef logic [PTR_W-1:0] ptr_t;

    // Advance a ring index by one, wrapping to zero at the entry count.
    function automatic ptr_t ring_next(input ptr_t p, input ptr_t n);
        logic [PTR_W:0] s;
        s = {1'b0, p} + 1'b1;
        return (s == {1'b0, n}) ? '0 : s[PTR_W-1:0];
    endfunction
endpackage

// File: rtl/qdb_decode.sv
// Address decode and validation for doorbell writes.
// Splits the window into interleaved tail/head slots, selects the queue,
// and accepts the write only if the queue exists and the value fits.
// Assumes DB_BASE is 8-byte aligned and NQ is at least 2. Purely combinational.
module qdb_decode
    import qdb_pkg::*;
#(
    parameter int NQ      = 64,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int DB_BASE = 'h1000,
    localparam int QID_W  = $clog2(NQ)
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NQ-1:0]       sq_valid,
    input  logic [NQ*PTR_W-1:0] sq_size,
    input  logic [NQ-1:0]       cq_valid,
    input  logic [NQ*PTR_W-1:0] cq_size,
    output logic                sq_we,
    output logic                cq_we,
    output logic [QID_W-1:0]    qid,
    output ptr_t                val
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] slot;
    logic              in_region;
    logic              aligned;
    logic              in_range;
    logic              is_head;
    logic              hit;
    ptr_t              sq_sz;
    ptr_t              cq_sz;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:PTR_W];

    // Offset arithmetic: window test, alignment, slot number and kind.
    always_comb begin
        rel       = wr_addr - ADDR_W'(DB_BASE);
        in_region = wr_addr >= ADDR_W'(DB_BASE);
        aligned   = (rel[1:0] == 2'b00);
        slot      = rel >> 3;
        in_range  = slot < ADDR_W'(NQ);
        is_head   = rel[2];
        qid       = slot[QID_W-1:0];
        val       = wr_data[PTR_W-1:0];
        hit       = wr_en && in_region && aligned && in_range;
    end

    // Per-queue configuration lookup and final acceptance.
    always_comb begin
        sq_sz = sq_size[qid*PTR_W +: PTR_W];
        cq_sz = cq_size[qid*PTR_W +: PTR_W];
        sq_we = hit && !is_head && sq_valid[qid] && (val < sq_sz);
        cq_we = hit &&  is_head && cq_valid[qid] && (val < cq_sz);
    end
endmodule

// File: rtl/qdb_ptr_bank.sv
// Bank of NQ pointer registers with a single indexed write port.
// Assumes the write has already been validated upstream.
module qdb_ptr_bank
    import qdb_pkg::*;
#(
    parameter int NQ     = 64,
    localparam int QID_W = $clog2(NQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [QID_W-1:0]    wqid,
    input  ptr_t                wval,
    output logic [NQ*PTR_W-1:0] ptrs
);
    for (genvar g = 0; g < NQ; g++) begin : g_q
        ptr_t r;

        // Hold this queue's pointer; load it when the write names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (we && (wqid == QID_W'(g)))
                r <= wval;
        end

        assign ptrs[g*PTR_W +: PTR_W] = r;
    end
endmodule

// File: rtl/qdb_events.sv
// Registers the event pulses for an accepted doorbell write.
// Fullness is judged against the head stored before this write and the
// poster tail presented in the same cycle. All outputs are one-cycle pulses.
module qdb_events
    import qdb_pkg::*;
#(
    parameter int NQ     = 64,
    localparam int QID_W = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sq_we,
    input  logic             cq_we,
    input  logic [QID_W-1:0] qid,
    input  ptr_t             new_val,
    input  ptr_t             old_head,
    input  ptr_t             tail_sel,
    input  ptr_t             size_sel,
    input  logic [NQ-1:0]    bind_row,
    output logic             fetch_vld,
    output logic [QID_W-1:0] fetch_qid,
    output logic             restart_vld,
    output logic [QID_W-1:0] restart_cqid,
    output logic [NQ-1:0]    restart_sqs,
    output logic             irq_vld,
    output logic [QID_W-1:0] irq_qid
);
    logic was_full;
    logic wake;
    logic renotify;

    // Decide which completion-side events this write causes.
    always_comb begin
        was_full = (ring_next(tail_sel, size_sel) == old_head);
        wake     = cq_we && was_full;
        renotify = cq_we && (new_val != tail_sel);
    end

    // Register the pulses and the queue numbers they carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_vld    <= 1'b0;
            fetch_qid    <= '0;
            restart_vld  <= 1'b0;
            restart_cqid <= '0;
            restart_sqs  <= '0;
            irq_vld      <= 1'b0;
            irq_qid      <= '0;
        end else begin
            fetch_vld    <= sq_we;
            fetch_qid    <= qid;
            restart_vld  <= wake;
            restart_cqid <= qid;
            restart_sqs  <= wake ? bind_row : '0;
            irq_vld      <= renotify;
            irq_qid      <= qid;
        end
    end
endmodule

// File: rtl/qdb_decoder.sv
// Doorbell decoder top: decode, two pointer banks and the event stage.
// Assumes configuration inputs are stable around a write and that the
// poster tail is the value current in the write cycle.
module qdb_decoder
    import qdb_pkg::*;
#(
    parameter int NQ      = 64,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int DB_BASE = 'h1000,
    localparam int QID_W  = $clog2(NQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NQ-1:0]       sq_valid,
    input  logic [NQ*PTR_W-1:0] sq_size,
    input  logic [NQ-1:0]       cq_valid,
    input  logic [NQ*PTR_W-1:0] cq_size,
    input  logic [NQ*PTR_W-1:0] cq_tail,
    input  logic [NQ*NQ-1:0]    cq_bind,
    output logic [NQ*PTR_W-1:0] sq_tail,
    output logic [NQ*PTR_W-1:0] cq_head,
    output logic                fetch_vld,
    output logic [QID_W-1:0]    fetch_qid,
    output logic                restart_vld,
    output logic [QID_W-1:0]    restart_cqid,
    output logic [NQ-1:0]       restart_sqs,
    output logic                irq_vld,
    output logic [QID_W-1:0]    irq_qid
);
    logic             sq_we;
    logic             cq_we;
    logic [QID_W-1:0] qid;
    ptr_t             val;
    ptr_t             old_head;
    ptr_t             tail_sel;
    ptr_t             size_sel;
    logic [NQ-1:0]    bind_row;

    qdb_decode #(
        .NQ(NQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DB_BASE(DB_BASE)
    ) decode_i (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sq_valid(sq_valid), .sq_size(sq_size),
        .cq_valid(cq_valid), .cq_size(cq_size),
        .sq_we(sq_we), .cq_we(cq_we), .qid(qid), .val(val)
    );

    qdb_ptr_bank #(.NQ(NQ)) sq_bank_i (
        .clk(clk), .rst_n(rst_n), .we(sq_we), .wqid(qid), .wval(val),
        .ptrs(sq_tail)
    );

    qdb_ptr_bank #(.NQ(NQ)) cq_bank_i (
        .clk(clk), .rst_n(rst_n), .we(cq_we), .wqid(qid), .wval(val),
        .ptrs(cq_head)
    );

    // Pick the addressed completion queue's state for the event stage.
    always_comb begin
        old_head = cq_head[qid*PTR_W +: PTR_W];
        tail_sel = cq_tail[qid*PTR_W +: PTR_W];
        size_sel = cq_size[qid*PTR_W +: PTR_W];
        bind_row = cq_bind[qid*NQ +: NQ];
    end

    qdb_events #(.NQ(NQ)) events_i (
        .clk(clk), .rst_n(rst_n),
        .sq_we(sq_we), .cq_we(cq_we), .qid(qid), .new_val(val),
        .old_head(old_head), .tail_sel(tail_sel), .size_sel(size_sel),
        .bind_row(bind_row),
        .fetch_vld(fetch_vld), .fetch_qid(fetch_qid),
        .restart_vld(restart_vld), .restart_cqid(restart_cqid),
        .restart_sqs(restart_sqs),
        .irq_vld(irq_vld), .irq_qid(irq_qid)
    );
endmodule

// File: rtl/qdb_checker.sv
// Temporal checks on the doorbell decoder, attached by bind.
// Keeps one-cycle copies of configuration so pulses can be related to the
// state seen at the write.
module qdb_checker
    import qdb_pkg::*;
#(
    parameter int NQ     = 64,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int QID_W = $clog2(NQ)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [NQ*PTR_W-1:0] sq_size,
    input logic [NQ*PTR_W-1:0] cq_tail,
    input logic [NQ*NQ-1:0]    cq_bind,
    input logic [NQ*PTR_W-1:0] sq_tail,
    input logic [NQ*PTR_W-1:0] cq_head,
    input logic                fetch_vld,
    input logic [QID_W-1:0]    fetch_qid,
    input logic                restart_vld,
    input logic [QID_W-1:0]    restart_cqid,
    input logic [NQ-1:0]       restart_sqs,
    input logic                irq_vld,
    input logic [QID_W-1:0]    irq_qid
);
    logic [NQ*PTR_W-1:0] tail_q;
    logic [NQ*PTR_W-1:0] sqsz_q;
    logic [NQ*NQ-1:0]    bind_q;
    logic                unused_bits;

    assign unused_bits = ^{wr_addr[ADDR_W-1:2], wr_data[DATA_W-1:PTR_W]};

    // Remember last cycle's configuration for comparison with pulses.
    always_ff @(posedge clk) begin
        tail_q <= cq_tail;
        sqsz_q <= sq_size;
        bind_q <= cq_bind;
    end

    a_r2_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr[1:0] != 2'b00)) |=>
            (!fetch_vld && !irq_vld && !restart_vld &&
             $stable(sq_tail) && $stable(cq_head)));

    a_r7_fetch_stores_data: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |-> (sq_tail[fetch_qid*PTR_W +: PTR_W] == $past(wr_data[PTR_W-1:0])));

    a_r6_fetch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |-> (sq_tail[fetch_qid*PTR_W +: PTR_W] < sqsz_q[fetch_qid*PTR_W +: PTR_W]));

    a_r8_restart_mask: assert property (@(posedge clk) disable iff (!rst_n)
        restart_vld |-> (restart_sqs == bind_q[restart_cqid*NQ +: NQ]));

    a_r9_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vld |-> (cq_head[irq_qid*PTR_W +: PTR_W] != tail_q[irq_qid*PTR_W +: PTR_W]));

    a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_vld && (irq_vld || restart_vld)));

    a_r10_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld || irq_vld || restart_vld) |-> $past(wr_en));
endmodule

bind qdb_decoder qdb_checker #(.NQ(NQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sq_size(sq_size), .cq_tail(cq_tail),
    .cq_bind(cq_bind), .sq_tail(sq_tail), .cq_head(cq_head),
    .fetch_vld(fetch_vld), .fetch_qid(fetch_qid),
    .restart_vld(restart_vld), .restart_cqid(restart_cqid),
    .restart_sqs(restart_sqs), .irq_vld(irq_vld), .irq_qid(irq_qid)
);

// File: tb/qdb_decoder_tb.sv
`timescale 1ns/1ps
// Bench for the doorbell decoder: a behavioural model over integer arrays
// predicts pointers and pulses, and is compared with the design every clock.
module qdb_decoder_tb_top;
    localparam int NQ = 64;
    localparam int QW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [NQ-1:0]     sq_valid = '0;
    logic [NQ*16-1:0]  sq_size = '0;
    logic [NQ-1:0]     cq_valid = '0;
    logic [NQ*16-1:0]  cq_size = '0;
    logic [NQ*16-1:0]  cq_tail = '0;
    logic [NQ*NQ-1:0]  cq_bind = '0;
    logic [NQ*16-1:0]  sq_tail;
    logic [NQ*16-1:0]  cq_head;
    logic              fetch_vld, restart_vld, irq_vld;
    logic [QW-1:0]     fetch_qid, restart_cqid, irq_qid;
    logic [NQ-1:0]     restart_sqs;

    int checks = 0;
    int errors = 0;
    int m_sq[NQ];
    int m_cq[NQ];
    bit e_fetch, e_rst, e_irq;
    int e_fq, e_rq, e_iq;
    logic [NQ-1:0] e_mask;

    always #10 clk = ~clk;

    qdb_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sq_valid(sq_valid), .sq_size(sq_size),
        .cq_valid(cq_valid), .cq_size(cq_size), .cq_tail(cq_tail),
        .cq_bind(cq_bind), .sq_tail(sq_tail), .cq_head(cq_head),
        .fetch_vld(fetch_vld), .fetch_qid(fetch_qid),
        .restart_vld(restart_vld), .restart_cqid(restart_cqid),
        .restart_sqs(restart_sqs), .irq_vld(irq_vld), .irq_qid(irq_qid)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Model one write (or idle cycle), advance one clock, compare everything.
    task automatic cycle(input bit we, input int addr, input logic [31:0] data,
                         input string req);
        int rel, q, v, t, s, old;
        bit ptr_ok;
        wr_en   = we;
        wr_addr = addr[15:0];
        wr_data = data;
        e_fetch = 0; e_rst = 0; e_irq = 0; e_fq = 0; e_rq = 0; e_iq = 0;
        e_mask  = '0;
        if (we && addr >= 'h1000 && (addr % 4) == 0) begin
            rel = addr - 'h1000;
            q   = rel / 8;
            v   = int'(data & 32'hFFFF);
            if (q < NQ) begin
                if (((rel / 4) % 2) == 0) begin
                    if (sq_valid[q] && v < int'(sq_size[q*16 +: 16])) begin
                        m_sq[q] = v; e_fetch = 1; e_fq = q;
                    end
                end else if (cq_valid[q] && v < int'(cq_size[q*16 +: 16])) begin
                    t   = int'(cq_tail[q*16 +: 16]);
                    s   = int'(cq_size[q*16 +: 16]);
                    old = m_cq[q];
                    m_cq[q] = v;
                    if (((t + 1) % s) == old) begin
                        e_rst = 1; e_rq = q; e_mask = cq_bind[q*NQ +: NQ];
                    end
                    if (v != t) begin
                        e_irq = 1; e_iq = q;
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(req, "fetch_vld", 64'(fetch_vld), 64'(e_fetch));
        if (e_fetch) chk(req, "fetch_qid", 64'(fetch_qid), 64'(e_fq));
        chk(req, "restart_vld", 64'(restart_vld), 64'(e_rst));
        if (e_rst) chk(req, "restart_cqid", 64'(restart_cqid), 64'(e_rq));
        chk(req, "restart_sqs", 64'(restart_sqs), 64'(e_mask));
        chk(req, "irq_vld", 64'(irq_vld), 64'(e_irq));
        if (e_irq) chk(req, "irq_qid", 64'(irq_qid), 64'(e_iq));
        ptr_ok = 1;
        for (int i = 0; i < NQ; i++) begin
            if (ptr_ok && int'(sq_tail[i*16 +: 16]) != m_sq[i]) begin
                chk(req, $sformatf("sq_tail[%0d]", i), 64'(sq_tail[i*16 +: 16]), 64'(m_sq[i]));
                ptr_ok = 0;
            end
            if (ptr_ok && int'(cq_head[i*16 +: 16]) != m_cq[i]) begin
                chk(req, $sformatf("cq_head[%0d]", i), 64'(cq_head[i*16 +: 16]), 64'(m_cq[i]));
                ptr_ok = 0;
            end
        end
        if (ptr_ok) chk(req, "pointers", 64'd0, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            m_sq[i] = 0;
            m_cq[i] = 0;
        end
        // Queue configuration for the scenarios below.
        foreach (sq_valid[i]) if (i == 0 || i == 1 || i == 2 || i == 5 || i == 63) begin
            sq_valid[i] = 1'b1;
            sq_size[i*16 +: 16] = 16'd8;
        end
        cq_valid[0] = 1'b1;  cq_size[0*16 +: 16]  = 16'd16; cq_tail[0*16 +: 16]  = 16'd5;
        cq_valid[1] = 1'b1;  cq_size[1*16 +: 16]  = 16'd4;  cq_tail[1*16 +: 16]  = 16'd2;
        cq_valid[2] = 1'b1;  cq_size[2*16 +: 16]  = 16'd4;  cq_tail[2*16 +: 16]  = 16'd3;
        cq_valid[63] = 1'b1; cq_size[63*16 +: 16] = 16'd8;  cq_tail[63*16 +: 16] = 16'd0;
        cq_bind[1*NQ + 1] = 1'b1;
        cq_bind[1*NQ + 5] = 1'b1;
        cq_bind[2*NQ + 2] = 1'b1;
        cq_bind[63*NQ + 63] = 1'b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(0, 0, 0, "R1");

        cycle(1, 'h1008, 32'hABCD_0005, "R4");          // sq1 tail 5, upper data ignored
        cycle(1, 'h1000, 32'h0000_0007, "R7");          // sq0 tail at size-1
        cycle(1, 'h1000, 32'h0000_0008, "R6");          // sq0 value equals size
        cycle(1, 'h1002, 32'h0000_0003, "R2");          // misaligned
        cycle(1, 'h0FFC, 32'h0000_0003, "R2");          // below window
        cycle(1, 'h1018, 32'h0000_0001, "R5");          // sq3 disabled
        cycle(1, 'h1200, 32'h0000_0001, "R5");          // queue 64 out of range
        cycle(1, 'h11F8, 32'h0000_0003, "R3");          // sq63 tail
        cycle(1, 'h1010, 32'h0000_0002, "R3");          // sq2 tail
        cycle(1, 'h1004, 32'h0000_0005, "R9");          // cq0 head == tail: no irq
        cycle(1, 'h1004, 32'h0000_0009, "R9");          // cq0 head != tail: irq
        cycle(1, 'h1014, 32'h0000_0001, "R8");          // cq2 full by wrap
        cycle(1, 'h100C, 32'h0000_0003, "R9");          // cq1 head 3, not full
        cycle(1, 'h100C, 32'h0000_0002, "R8");          // cq1 was full: wake sq1, sq5
        cycle(1, 'h100C, 32'h0000_0004, "R6");          // cq1 value equals size
        cycle(1, 'h101C, 32'h0000_0001, "R5");          // cq3 disabled
        cycle(1, 'h11FC, 32'h0000_0007, "R3");          // cq63 head
        cycle(1, 'h1028, 32'h0000_0006, "R10");         // sq5, back to back
        cycle(1, 'h1008, 32'h0000_0001, "R10");         // sq1, back to back
        cycle(0, 0, 0, "R10");                          // idle: no pulses
        cycle(0, 0, 0, "R10");

        summary();
        $finish;
    end
endmodule